// File: doc/BRIEF.md
# RC-Time Capacitance Meter Controller

This controller measures an unknown capacitor by timing how long it takes to charge to a fixed fraction of the supply. An external comparator watches the capacitor voltage and reports high while that voltage is still below 0.63 of the supply. Pressing start opens a measurement window and releases the discharge switch, so the capacitor starts charging through the selected resistor. Reference pulses are counted until the comparator drops. The count is then frozen and shown as a four-digit decimal result.

A two-bit range input picks the counting reference and the charging resistor. The fast reference runs at 1 MHz. The slow reference is 1 kHz and is derived inside the block from the fast pulses by three cascaded decade stages. Outside a window the capacitor is always held shorted. An abort input ends a window at once, so a new reading need not wait for the 15-second window to run out.

Top module: `rc_cap_timer`

## Requirements
- R1: After reset, and at any time no window is open, `discharge_on` is 1 and `charging_led` is 0. After reset, `result_bcd` is 0 and `overflow` is 0.
- R2: A synchronized rising edge of `start_btn`, seen while no window is open and abort is low, opens a window. `discharge_on` goes to 0 within a few cycles. The window closes by itself after `WINDOW_CYCLES` clock cycles, and `discharge_on` then returns to 1.
- R3: The running count advances by one for each selected reference pulse during which a window is open, the synchronized comparator is high and no fall has yet been seen in this window. At no other time does it advance.
- R4: The first synchronized falling edge of `comp_in` inside a window copies the running count into `result_bcd`. No pulse after that fall is added. A later rise of the comparator does not resume counting in the same window.
- R5: `range_sel` encoding: 0 selects the 1 MHz reference (`ref_tick`) with the 1 megohm resistor. 1 selects the slow reference with 1 megohm. 2 or 3 selects the slow reference with 1 kilohm. `res_sel_1k` is 1 only for the 1 kilohm resistor.
- R6: The slow reference pulses together with every DIV_RATIO^DIV_STAGES-th `ref_tick` pulse counted since reset. With the defaults this is every 1000th pulse.
- R7: While synchronized abort is high, any window closes within a few cycles and no window can open. `result_bcd` keeps its value.
- R8: `charging_led` is 1 exactly while counting is enabled. It drops once the comparator fall has been seen.
- R9: The count is a four-digit BCD value (digit 0 in bits 3:0). It saturates at 9999. A selected pulse that arrives while the count is at 9999 sets an overflow condition. `overflow` is latched together with `result_bcd`.
- R10: Start is edge-detected. A button held high triggers only one window, even after that window has been aborted.
- R11: The running count is cleared when a window opens. `result_bcd` keeps the previous result until the new fall latches. A window that expires without a fall leaves `result_bcd` unchanged.
- R12: A start edge that arrives while a window is already open is ignored. The running count is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_btn | input | 1 | Start request, asynchronous level |
| abort_btn | input | 1 | Abort, asynchronous level; ends the window |
| comp_in | input | 1 | Comparator, high while the capacitor is below threshold |
| ref_tick | input | 1 | One-cycle pulse at the 1 MHz reference rate |
| range_sel | input | 2 | Measurement range select |
| discharge_on | output | 1 | High shorts the capacitor |
| charging_led | output | 1 | High while counting |
| res_sel_1k | output | 1 | 1 selects the 1 kilohm charging resistor, 0 selects 1 megohm |
| result_bcd | output | 16 | Latched four-digit BCD result |
| overflow | output | 1 | Latched saturation flag |

## Verification
The bench counts, at the ports, the selected reference pulses seen while `charging_led` is high. It compares that number with the latched result on every range. A design that added one pulse too many at the fall, or that took the slow reference at the wrong division ratio, would show a wrong count. A long charge drives the counter into saturation: a wrapping counter would show a small value, and a missing flag would leave `overflow` at 0.

Several timing cases are aimed at specifically:
- a comparator that rises again after the latch, which a design without a stop condition would count on;
- a second start pressed mid-window, which would clear the count;
- a start held through an abort, which a level-triggered design would turn into a second window;
- a window that expires with no fall, which a careless latch would overwrite.

// File: rtl/rc_cap_timer.sv
module rc_cap_timer #(
  parameter int unsigned     DIV_RATIO     = 10,
  parameter int unsigned     DIV_STAGES    = 3,
  parameter longint unsigned WINDOW_CYCLES = 64'd3000000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_btn,
  input  logic        abort_btn,
  input  logic        comp_in,
  input  logic        ref_tick,
  input  logic [1:0]  range_sel,
  output logic        discharge_on,
  output logic        charging_led,
  output logic        res_sel_1k,
  output logic [15:0] result_bcd,
  output logic        overflow
);

  localparam int WCW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam int DCW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [WCW-1:0] WIN_LAST = WCW'(WINDOW_CYCLES - 1);
  localparam logic [DCW-1:0] DIV_LAST = DCW'(DIV_RATIO - 1);
  localparam logic [15:0]    BCD_MAX  = 16'h9999;

  logic [1:0]     st_sy, ab_sy, cp_sy;
  logic           st_q, cp_q;
  logic           window, done, ovf_run;
  logic [WCW-1:0] win_cnt;
  logic [15:0]    cnt;
  logic [DIV_STAGES:0] carry;

  wire start_s  = st_sy[1];
  wire abort_s  = ab_sy[1];
  wire comp_s   = cp_sy[1];
  wire open_win = start_s && !st_q && !window && !abort_s;
  wire comp_fall = cp_q && !comp_s;
  wire count_en = window && comp_s && !done;
  wire slow_tick = carry[DIV_STAGES];
  wire sel_tick = (range_sel == 2'd0) ? ref_tick : slow_tick;

  assign discharge_on = !window;
  assign charging_led = count_en;
  assign res_sel_1k   = range_sel[1];

  function automatic logic [15:0] bcd_inc(input logic [15:0] v);
    logic c;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c) begin
        if (v[4*i +: 4] == 4'd9) v[4*i +: 4] = 4'd0;
        else begin
          v[4*i +: 4] = v[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sy <= '0; ab_sy <= '0; cp_sy <= '0;
      st_q  <= 1'b0; cp_q <= 1'b0;
    end else begin
      st_sy <= {st_sy[0], start_btn};
      ab_sy <= {ab_sy[0], abort_btn};
      cp_sy <= {cp_sy[0], comp_in};
      st_q  <= start_s;
      cp_q  <= comp_s;
    end
  end

  assign carry[0] = ref_tick;
  for (genvar g = 0; g < DIV_STAGES; g++) begin : g_div
    logic [DCW-1:0] dc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dc <= '0;
      else if (carry[g]) dc <= (dc == DIV_LAST) ? '0 : dc + 1'b1;
    end
    assign carry[g+1] = carry[g] && (dc == DIV_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window  <= 1'b0;
      win_cnt <= '0;
    end else if (abort_s) begin
      window <= 1'b0;
    end else if (open_win) begin
      window  <= 1'b1;
      win_cnt <= '0;
    end else if (window) begin
      if (win_cnt == WIN_LAST) window <= 1'b0;
      else win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      cnt     <= '0;
      ovf_run <= 1'b0;
    end else if (open_win) begin
      done    <= 1'b0;
      cnt     <= '0;
      ovf_run <= 1'b0;
    end else begin
      if (window && comp_fall) done <= 1'b1;
      if (count_en && sel_tick) begin
        if (cnt == BCD_MAX) ovf_run <= 1'b1;
        else cnt <= bcd_inc(cnt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_bcd <= '0;
      overflow   <= 1'b0;
    end else if (window && !done && comp_fall) begin
      result_bcd <= cnt;
      overflow   <= ovf_run;
    end
  end

  p_open_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_win |=> !discharge_on);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !open_win) |=> $stable(cnt));

  p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (window && !done && comp_fall) |=> (result_bcd == $past(cnt)));

  p_slow_sparse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |-> ref_tick);

  p_abort_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_s |=> discharge_on);

  p_led_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !charging_led);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == BCD_MAX && !open_win) |=> (cnt == BCD_MAX));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(window && !done && comp_fall) |=> $stable(result_bcd));

endmodule

// File: tb/rc_cap_timer_tb_top.sv
`timescale 1ns/100ps
module rc_cap_timer_tb_top;
  localparam int DIV = 2;
  localparam int STG = 3;
  localparam int SLOW = DIV ** STG;
  localparam int WIN = 30000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_btn = 1'b0, abort_btn = 1'b0, comp_in = 1'b1, ref_tick = 1'b0;
  logic [1:0] range_sel = 2'd0;
  logic discharge_on, charging_led, res_sel_1k, overflow;
  logic [15:0] result_bcd;

  int n_chk = 0, n_fail = 0;
  int model = 0, refn = 0;
  bit tick_on = 0;

  always #2.5 clk = ~clk;

  rc_cap_timer #(.DIV_RATIO(DIV), .DIV_STAGES(STG), .WINDOW_CYCLES(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .abort_btn(abort_btn),
    .comp_in(comp_in), .ref_tick(ref_tick), .range_sel(range_sel),
    .discharge_on(discharge_on), .charging_led(charging_led),
    .res_sel_1k(res_sel_1k), .result_bcd(result_bcd), .overflow(overflow));

  initial forever begin
    @(posedge clk);
    #1;
    ref_tick = tick_on ? ~ref_tick : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && ref_tick) begin
      refn = refn + 1;
      if (charging_led && (range_sel == 2'd0 || (refn % SLOW) == 0))
        model = model + 1;
    end
  end

  function automatic logic [15:0] to_bcd(input int n);
    int v;
    v = (n > 9999) ? 9999 : n;
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_start();
    start_btn = 1'b1; cyc(3); start_btn = 1'b0; cyc(1);
  endtask

  task automatic do_abort();
    abort_btn = 1'b1; cyc(5); abort_btn = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    chk("R1 discharge", discharge_on, 1);
    chk("R1 led", charging_led, 0);
    chk("R1 result", result_bcd, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_measure(input logic [1:0] rng, input int hold);
    logic [15:0] exp;
    range_sel = rng; comp_in = 1'b1; cyc(2);
    chk("R5 res_sel", res_sel_1k, rng[1]);
    model = 0;
    press_start(); cyc(3);
    chk("R2 discharge released", discharge_on, 0);
    chk("R8 led on", charging_led, 1);
    cyc(hold);
    comp_in = 1'b0; cyc(6);
    exp = to_bcd(model);
    chk("R8 led off", charging_led, 0);
    chk("R3 R4 R6 result", result_bcd, exp);
    chk("R9 overflow", overflow, (model > 9999) ? 1 : 0);
    comp_in = 1'b1; cyc(40);
    chk("R4 no resume led", charging_led, 0);
    chk("R4 no resume result", result_bcd, exp);
    do_abort();
    chk("R7 discharge", discharge_on, 1);
    chk("R7 result kept", result_bcd, exp);
  endtask

  task automatic t_keep_old();
    logic [15:0] old;
    old = result_bcd;
    range_sel = 2'd0; comp_in = 1'b1; model = 0;
    press_start(); cyc(100);
    chk("R11 old result kept", result_bcd, old);
    comp_in = 1'b0; cyc(6);
    chk("R11 cleared count", result_bcd, to_bcd(model));
    comp_in = 1'b1; do_abort();
  endtask

  task automatic t_restart_ignored();
    range_sel = 2'd1; comp_in = 1'b1; model = 0;
    press_start(); cyc(200);
    press_start(); cyc(200);
    comp_in = 1'b0; cyc(6);
    chk("R12 second start ignored", result_bcd, to_bcd(model));
    comp_in = 1'b1; do_abort();
  endtask

  task automatic t_held_start();
    start_btn = 1'b1; cyc(8);
    chk("R10 first open", discharge_on, 0);
    abort_btn = 1'b1; cyc(5); abort_btn = 1'b0; cyc(20);
    chk("R10 held start no reopen", discharge_on, 1);
    start_btn = 1'b0; cyc(4);
  endtask

  task automatic t_abort_blocks();
    abort_btn = 1'b1; cyc(4);
    press_start(); cyc(4);
    chk("R7 start blocked", discharge_on, 1);
    abort_btn = 1'b0; cyc(4);
  endtask

  task automatic t_expire();
    logic [15:0] old;
    old = result_bcd;
    range_sel = 2'd2; comp_in = 1'b1;
    press_start(); cyc(50);
    chk("R2 window open", discharge_on, 0);
    cyc(WIN + 20);
    chk("R2 window expired", discharge_on, 1);
    chk("R11 expiry result kept", result_bcd, old);
    chk("R1 led idle", charging_led, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(4);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    tick_on = 1;
    cyc(2);
    t_measure(2'd0, 300);
    t_measure(2'd1, 400);
    t_measure(2'd2, 300);
    t_measure(2'd3, 200);
    t_keep_old();
    t_restart_ignored();
    t_held_start();
    t_abort_blocks();
    t_measure(2'd0, 21000);
    t_expire();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule